// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block divides an input clock by a programmable ratio with a resolution of half an input period. A front stage that can stretch one output period by a single half-period sits ahead of a chain of seven divide-by-2/3 cells. Each 2/3 cell adds at most one extra input period per output period, on request from the cell behind it. The chain's end-of-period event is retimed against the input clock by a pair of registers, one for each clock half. These registers produce the fractional output. A toggle stage driven by the rising edges of that output produces an exact 50% duty output at twice the ratio. This holds for odd integer ratios as well.

Both outputs are presented as a two-bit half-period pair for each input cycle. Bit 1 is the output level during the first half of the cycle, after the rising input edge. Bit 0 is the level during the second half. A double-data-rate output register, or an equivalent element, turns the pair into a real clock. A mode input selects which of the two outputs is driven. The other output is held low. The ratio word is taken in only at the end of an output period, so a new ratio never produces a malformed period.

Top module: `halfstep_clk_div`

## Requirements
- R1: With ratio word R (unsigned, 0 to 255), consecutive rising edges of the fractional output are 256+R input half-periods apart. Bit 0 of R is worth half an input period. Bits 7..1 are worth 1, 2, 4 up to 64 input periods.
- R2: R=0 gives the shortest period, 128 input periods (256 half-periods). R=255 gives the longest, 255.5 input periods (511 half-periods). For example, a 2.56 GHz input divided at R=255 gives about 10.02 MHz.
- R3: In integer mode, consecutive rising edges of the output are 2*(256+R) half-periods apart. The output is high for exactly 256+R half-periods, which is half of that period, for odd and even R alike. R=255 turns 1.28 GHz into about 2.504 MHz.
- R4: The ratio word is sampled only at an output-period boundary. If the word changes partway through a period, that period completes with the old length, and the new length applies from the next period.
- R5: With int_mode_i=0, frac_clk_o is driven and int_clk_o stays 2'b00. With int_mode_i=1, int_clk_o is driven and frac_clk_o stays 2'b00. In each output pair, bit 1 is the level in the first half of the input cycle and bit 0 the level in the second half.
- R6: A synchronous active-high reset clears both outputs to 2'b00. Both outputs stay 2'b00 for at least the first five cycles after reset is released.
- R7: Each fractional output pulse is high for exactly 2 input half-periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 8 | Ratio word: bit 0 is the half step, bits 7..1 are binary weighted |
| int_mode_i | input | 1 | 0 drives the fractional output, 1 drives the 50% duty integer output |
| frac_clk_o | output | 2 | Fractional output as a half-period pair, bit 1 is the first half |
| int_clk_o | output | 2 | 50% duty integer output as a half-period pair, bit 1 is the first half |

## Verification
Two functions can fall in the same cycle: a half-step stretch by the front stage and the chain's end-of-period event, which also loads the ratio word. Whenever bit 0 is set, the stretch lands in the last front-stage period of every output period. Depending on the current half-phase, the stretch either moves the final pulse into the falling half of the same cycle or pushes it into the next cycle. The bench sweeps every ratio code in a scrambled order and changes the word right after each rising edge. It judges the period that was already running against the old code and the next period against the new code, so a ratio load that coincides with a stretch shows up as a wrong half-period count.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;
  // Half-period pair: [1] level after the rising input edge, [0] after the falling one
  typedef logic [1:0] half_pair_t;

  localparam half_pair_t PAIR_LOW       = 2'b00;
  localparam half_pair_t PAIR_HIGH      = 2'b11;
  localparam half_pair_t PAIR_RISE_LATE = 2'b01;
  localparam half_pair_t PAIR_FALL_LATE = 2'b10;
endpackage

// File: rtl/hs_front_cell.sv
// Half-step front stage: nominally one pulse per input cycle; when asked,
// stretches one of its periods by one input half-period.
module hs_front_cell (
  input  logic clk,
  input  logic rst,
  input  logic stretch_en_i,   // half-step bit of the ratio
  input  logic mod_i,          // request from the first 2/3 cell
  output logic pulse_o,        // pulse this cycle
  output logic late_o          // pulse sits in the falling half
);
  logic late_q;   // current half-phase of the pulse train
  logic done_q;   // stretch already taken, waiting for the delayed pulse
  logic want;

  assign want = stretch_en_i & mod_i & ~done_q;

  always_comb begin
    if (want && !late_q) begin
      pulse_o = 1'b1;
      late_o  = 1'b1;
    end else if (want && late_q) begin
      pulse_o = 1'b0;
      late_o  = 1'b0;
    end else begin
      pulse_o = 1'b1;
      late_o  = late_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      late_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      late_q <= want ? ~late_q : late_q;
      done_q <= want & late_q;
    end
  end

  // R1: a stretch never costs more than one missing pulse
  a_r1_no_double_gap: assert property (@(posedge clk) disable iff (rst)
    !pulse_o |=> pulse_o);
endmodule

// File: rtl/hs_mod_cell.sv
// Divide-by-2/3 cell driven by enable pulses from the faster neighbour.
module hs_mod_cell (
  input  logic clk,
  input  logic rst,
  input  logic en_i,       // one pulse per input period of this cell
  input  logic mod_i,      // request from the slower neighbour
  input  logic swallow_i,  // ratio bit of this cell
  output logic en_o,       // end of this cell's output period
  output logic mod_o       // request toward the faster neighbour
);
  logic [1:0] cnt_q;
  logic       last;

  assign last  = (cnt_q == ((swallow_i && mod_i) ? 2'd2 : 2'd1));
  assign en_o  = en_i & last;
  assign mod_o = mod_i & last;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= 2'd0;
    else if (en_i) cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
  end

  // R1: the third count exists only while a swallow is requested
  a_r1_swallow_on_request: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == 2'd2) |-> (swallow_i && mod_i));
endmodule

// File: rtl/hs_retime.sv
// Retiming stage: two registers (one per clock half) form the fractional
// pulse; a toggle forms the 50% duty integer output.
module hs_retime
  import hsdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_i,       // chain end-of-period event
  input  logic       ev_late_i,  // event lies in the falling half
  input  logic       int_mode_i,
  output half_pair_t frac_o,
  output half_pair_t int_o
);
  logic       carry_q;
  logic       tog_q;
  half_pair_t frac_n, int_n;
  half_pair_t frac_q, int_q;

  always_comb begin
    if (ev_i && !ev_late_i) frac_n = PAIR_HIGH;
    else if (ev_i)          frac_n = PAIR_RISE_LATE;
    else if (carry_q)       frac_n = PAIR_FALL_LATE;
    else                    frac_n = PAIR_LOW;

    if (ev_i && !ev_late_i) int_n = {~tog_q, ~tog_q};
    else if (ev_i)          int_n = {tog_q, ~tog_q};
    else                    int_n = {tog_q, tog_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      tog_q   <= 1'b0;
      frac_q  <= PAIR_LOW;
      int_q   <= PAIR_LOW;
      frac_o  <= PAIR_LOW;
      int_o   <= PAIR_LOW;
    end else begin
      carry_q <= ev_i & ev_late_i;
      tog_q   <= ev_i ? ~tog_q : tog_q;
      frac_q  <= frac_n;
      int_q   <= int_n;
      frac_o  <= int_mode_i ? PAIR_LOW : frac_n;
      int_o   <= int_mode_i ? int_n : PAIR_LOW;
    end
  end

  // R7: a pulse starting in the rising half ends after it
  a_r7_pulse_early: assert property (@(posedge clk) disable iff (rst)
    (frac_q == PAIR_HIGH) |=> (frac_q == PAIR_LOW));
  // R7: a pulse starting in the falling half covers the next rising half only
  a_r7_pulse_late: assert property (@(posedge clk) disable iff (rst)
    (frac_q == PAIR_RISE_LATE) |=> (frac_q == PAIR_FALL_LATE));
  // R3: a late rise of the integer output is followed by a full high cycle
  a_r3_rise_holds: assert property (@(posedge clk) disable iff (rst)
    (int_q == PAIR_RISE_LATE) |=> (int_q == PAIR_HIGH));
  // R3: a late fall of the integer output is followed by a full low cycle
  a_r3_fall_holds: assert property (@(posedge clk) disable iff (rst)
    (int_q == PAIR_FALL_LATE) |=> (int_q == PAIR_LOW));
endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div
  import hsdiv_pkg::*;
#(
  parameter int N_CELLS = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS:0]   ratio_i,
  input  logic               int_mode_i,
  output logic [1:0]         frac_clk_o,
  output logic [1:0]         int_clk_o
);
  localparam int RW = N_CELLS + 1;

  logic [RW-1:0]      ratio_q;
  logic               front_pulse, front_late;
  logic [N_CELLS-1:0] en_out, mod_out;
  logic               boundary;
  half_pair_t         frac_pair, int_pair;

  // ratio word is taken in only at a period boundary
  always_ff @(posedge clk) begin
    if (rst || boundary) ratio_q <= ratio_i;
  end

  hs_front_cell u_front (
    .clk          (clk),
    .rst          (rst),
    .stretch_en_i (ratio_q[0]),
    .mod_i        (mod_out[0]),
    .pulse_o      (front_pulse),
    .late_o       (front_late)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic en_in, mod_in;
    if (k == 0) begin : g_head
      assign en_in = front_pulse;
    end else begin : g_body
      assign en_in = en_out[k-1];
    end
    if (k == N_CELLS - 1) begin : g_tail
      assign mod_in = 1'b1;
    end else begin : g_link
      assign mod_in = mod_out[k+1];
    end
    hs_mod_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_in),
      .mod_i     (mod_in),
      .swallow_i (ratio_q[k+1]),
      .en_o      (en_out[k]),
      .mod_o     (mod_out[k])
    );
  end

  assign boundary = en_out[N_CELLS-1];

  hs_retime u_retime (
    .clk        (clk),
    .rst        (rst),
    .ev_i       (boundary),
    .ev_late_i  (front_late),
    .int_mode_i (int_mode_i),
    .frac_o     (frac_pair),
    .int_o      (int_pair)
  );

  assign frac_clk_o = frac_pair;
  assign int_clk_o  = int_pair;

  // R4: the held ratio moves only at a chain boundary
  a_r4_ratio_held: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(ratio_q));
  // R5: only the selected output may carry a level
  a_r5_one_output: assert property (@(posedge clk) disable iff (rst)
    !((frac_clk_o != 2'b00) && (int_clk_o != 2'b00)));
endmodule

// File: tb/test_halfstep_clk_div.sv
`timescale 1ns/1ps
module test_halfstep_clk_div;
  localparam int N_CELLS = 7;
  localparam int BASE_H  = 2 ** (N_CELLS + 1);
  localparam int WDOG    = 195000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_CELLS:0] ratio_i = '0;
  logic             int_mode_i = 1'b0;
  logic [1:0]       frac_clk_o, int_clk_o;

  halfstep_clk_div #(.N_CELLS(N_CELLS)) i_halfstep_clk_div (
    .clk(clk), .rst(rst), .ratio_i(ratio_i), .int_mode_i(int_mode_i),
    .frac_clk_o(frac_clk_o), .int_clk_o(int_clk_o));

  always #10 clk = ~clk;   // 50 MHz

  int total = 0, bad = 0;
  longint cyc = 0;
  bit timed_out = 0;

  // monitor state
  longint last_rise = 0, period_last = 0, high_last = 0, hi_acc = 0;
  int rise_cnt = 0, frac_nz = 0, int_nz = 0;
  bit have_rise = 0, prev_lvl = 0;

  function automatic longint frac_half(input int code);
    return BASE_H + code;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WDOG && !timed_out) begin
      timed_out = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [1:0] pr;
      pr = frac_clk_o | int_clk_o;
      if (frac_clk_o != 2'b00) frac_nz++;
      if (int_clk_o != 2'b00) int_nz++;
      for (int h = 0; h < 2; h++) begin
        bit l;
        longint pos;
        l = (h == 0) ? pr[1] : pr[0];
        pos = 2 * cyc + h;
        if (l && !prev_lvl) begin
          if (have_rise) begin
            period_last = pos - last_rise;
            high_last = hi_acc;
          end
          last_rise = pos;
          have_rise = 1;
          hi_acc = 0;
          rise_cnt++;
        end
        if (l) hi_acc++;
        prev_lvl = l;
      end
    end
  end

  task automatic check_eq(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rises(input int n);
    int target;
    target = rise_cnt + n;
    while (rise_cnt < target) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    int prev_code;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R6: outputs low right after reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check_eq("R6 frac after reset", frac_clk_o, 0);
      check_eq("R6 int after reset", int_clk_o, 0);
    end
    wait_rises(2);
    frac_nz = 0; int_nz = 0;
    prev_code = 0;
    // fractional sweep over every code, scrambled order
    for (int i = 0; i < 256; i++) begin
      int code;
      code = (i * 37 + 11) % 256;
      ratio_i = code[N_CELLS:0];
      wait_rises(1);
      check_eq("R4 running period keeps old ratio", period_last, frac_half(prev_code));
      wait_rises(1);
      if (code == 0 || code == 255)
        check_eq("R2 extreme ratio period", period_last, frac_half(code));
      else
        check_eq("R1 fractional period", period_last, frac_half(code));
      check_eq("R7 pulse width", high_last, 2);
      prev_code = code;
    end
    check_eq("R5 integer output idle in fractional mode", int_nz, 0);

    // integer mode
    int_mode_i = 1'b1;
    wait_rises(3);
    frac_nz = 0;
    for (int i = 0; i < 20; i++) begin
      int code;
      case (i)
        0: code = 255;
        1: code = 0;
        2: code = 1;
        3: code = 254;
        default: code = $urandom % 256;
      endcase
      ratio_i = code[N_CELLS:0];
      wait_rises(2);
      check_eq("R3 integer period", period_last, 2 * frac_half(code));
      check_eq("R3 integer high time", high_last, frac_half(code));
    end
    check_eq("R5 fractional output idle in integer mode", frac_nz, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule